// File: doc/BRIEF.md
# Bus Parallel Poll Responder

This block answers a controller's parallel poll on an instrument bus interface. A host-side register port holds an 8-bit poll enable mask. The block ANDs the mask with the live status byte and reduces the result to a single individual status bit (ist). While the poll strobe is high, the block drives that bit onto one of the eight data lines, but only if ist matches a chosen polarity.

The line and the polarity come from the bus in two steps. First a configure command byte arms the responder. Then an enable command byte supplies the sense bit and the 3-bit line position. Either a local disable input or a disable command byte that follows a configure byte returns the responder to the unconfigured state. An unconfigured responder keeps all data lines low.

Top module: `ppoll_responder`

## Requirements
- R1: A write on the register port stores all 8 bits of `reg_wdata` in the enable mask. From the next cycle, `reg_rdata` returns the stored mask unchanged.
- R2: `ist` is 1 when `mask & stat_byte` has at least one bit set, and 0 when the result is all zeros. It follows `stat_byte` with no clock delay.
- R3: Configuration takes two steps. A command byte equal to 0x05 arms the responder. If the next command byte has bits 6:4 equal to 3'b110, it configures the responder. Bit 7 of that byte is ignored. The new setting applies from the cycle after that byte is taken.
- R4: Bit 3 of the enable byte is the sense. A configured responder asserts a line only when `ist` equals the sense.
- R5: Bits 2:0 of the enable byte give the position n. A response is exactly `1 << n` on `poll_data`, and all other lines stay low.
- R6: An enable byte that arrives while the responder is not armed has no effect. Any command byte after 0x05 other than 0x05, an enable byte or a disable byte cancels the armed state, so a later enable byte is ignored.
- R7: A high `local_dis`, or a byte with bits 6:4 equal to 3'b111 taken while armed, clears the configuration. Later polls then return 0x00.
- R8: `poll_data` is 0x00 whenever `poll_req` is low. While `poll_req` is high, it follows `stat_byte` with no clock delay.
- R9: After reset the mask is 0x00 and the responder is unconfigured and not armed.
- R10: A new 0x05 followed by an enable byte replaces the stored sense and position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the enable mask |
| reg_wdata | input | 8 | Mask value to write |
| reg_rdata | output | 8 | Current enable mask |
| cmd_valid | input | 1 | Qualifies `cmd_byte` for one cycle |
| cmd_byte | input | 8 | Command byte received from the bus |
| stat_byte | input | 8 | Live status byte |
| poll_req | input | 1 | Parallel poll strobe from the controller |
| local_dis | input | 1 | Clears the poll configuration |
| ist | output | 1 | Individual status bit |
| poll_data | output | 8 | Data-line response during a poll |

## Verification
The assertions take `cmd_valid` to be a single-cycle strobe and expect each bus command to be held for exactly one clock. They also take register writes to be sampled at the same edge as commands. The stimulus drives every input on the falling edge, so each strobe covers exactly one rising edge. The bench changes `stat_byte` and `poll_req` only between edges, so the combinational response can be sampled with no race against state updates.

// File: rtl/ppoll_responder.sv
module ppoll_responder #(
  parameter logic [7:0] CFG_CODE = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic [7:0] stat_byte,
  input  logic       poll_req,
  input  logic       local_dis,
  output logic       ist,
  output logic [7:0] poll_data
);
  localparam logic [2:0] EN_TAG  = 3'b110;
  localparam logic [2:0] DIS_TAG = 3'b111;

  logic [7:0] mask_q;
  logic       armed_q, cfg_q, sense_q;
  logic [2:0] pos_q;

  wire is_cfg = cmd_valid && (cmd_byte == CFG_CODE);
  wire is_en  = cmd_valid && (cmd_byte[6:4] == EN_TAG);
  wire is_dis = cmd_valid && (cmd_byte[6:4] == DIS_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      armed_q <= 1'b0;
      cfg_q   <= 1'b0;
      sense_q <= 1'b0;
      pos_q   <= '0;
    end else begin
      if (reg_wr) mask_q <= reg_wdata;
      if (local_dis) begin
        armed_q <= 1'b0;
        cfg_q   <= 1'b0;
      end else if (cmd_valid) begin
        armed_q <= is_cfg;
        if (armed_q && is_en) begin
          cfg_q   <= 1'b1;
          sense_q <= cmd_byte[3];
          pos_q   <= cmd_byte[2:0];
        end
        if (armed_q && is_dis) cfg_q <= 1'b0;
      end
    end
  end

  assign reg_rdata = mask_q;
  assign ist       = |(mask_q & stat_byte);

  wire respond = poll_req && cfg_q && (ist == sense_q);
  assign poll_data = respond ? (8'b1 << pos_q) : 8'h00;

  // R1
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata == $past(reg_wdata));

  // R3
  enable_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && is_en && !local_dis) |=> (cfg_q && sense_q == $past(cmd_byte[3]) && pos_q == $past(cmd_byte[2:0])));

  // R6
  unarmed_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !cfg_q && cmd_valid) |=> !cfg_q);

  // R7
  local_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    local_dis |=> (!cfg_q && !armed_q && poll_data == 8'h00));

  // R5
  onehot_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(poll_data));

  // R8
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_req |-> poll_data == 8'h00);
endmodule

// File: tb/ppoll_responder_tb.sv
module ppoll_responder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic [7:0] stat_byte = '0;
  logic       poll_req = 1'b0;
  logic       local_dis = 1'b0;
  logic       ist;
  logic [7:0] poll_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ppoll_responder u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .stat_byte(stat_byte), .poll_req(poll_req), .local_dis(local_dis),
    .ist(ist), .poll_data(poll_data)
  );

  // {mask, enable byte, status, expected poll_data}
  localparam logic [31:0] VEC [10] = '{
    32'h40_69_40_02, 32'h40_69_00_00, 32'h81_6F_01_80, 32'h81_6F_10_00,
    32'hFF_63_00_08, 32'hFF_63_20_00, 32'h0C_E8_04_01, 32'h00_6A_FF_00,
    32'h00_62_FF_04, 32'h3C_6D_08_20
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = m;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_dis();
    @(negedge clk);
    local_dis = 1'b1;
    @(negedge clk);
    local_dis = 1'b0;
  endtask

  task automatic poll_at(input logic [7:0] s, output logic [7:0] r);
    stat_byte = s;
    poll_req  = 1'b1;
    #1;
    r = poll_data;
    poll_req = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 mask", reg_rdata, 8'h00);
    poll_at(8'hFF, r);
    check("R9 unconfigured", r, 8'h00);

    for (int i = 0; i < 10; i++) begin
      write_mask(VEC[i][31:24]);
      check("R1 readback", reg_rdata, VEC[i][31:24]);
      send_cmd(8'h05);
      send_cmd(VEC[i][23:16]);
      poll_at(VEC[i][15:8], r);
      check("R2 ist", {7'b0, ist}, {7'b0, |(VEC[i][31:24] & VEC[i][15:8])});
      check("R3 R4 R5 response", r, VEC[i][7:0]);
    end

    // R8 strobe low gives zero
    stat_byte = 8'h08;
    #1;
    check("R8 idle", poll_data, 8'h00);
    poll_at(8'h00, r);
    check("R8 follows status", r, 8'h00);
    poll_at(8'h08, r);
    check("R8 follows status", r, 8'h20);

    // R7 local disable
    pulse_dis();
    poll_at(8'h08, r);
    check("R7 local disable", r, 8'h00);

    // R6 enable without configure ignored
    send_cmd(8'h69);
    write_mask(8'h40);
    poll_at(8'h40, r);
    check("R6 unarmed enable", r, 8'h00);

    // R6 other byte cancels armed state
    send_cmd(8'h05);
    send_cmd(8'h3F);
    send_cmd(8'h69);
    poll_at(8'h40, r);
    check("R6 cancel", r, 8'h00);

    // R10 reconfigure
    send_cmd(8'h05);
    send_cmd(8'h69);
    poll_at(8'h40, r);
    check("R10 first", r, 8'h02);
    send_cmd(8'h05);
    send_cmd(8'h64);
    poll_at(8'h40, r);
    check("R10 replaced", r, 8'h00);
    poll_at(8'h00, r);
    check("R10 replaced", r, 8'h10);

    // R7 disable command after configure
    send_cmd(8'h05);
    send_cmd(8'h70);
    poll_at(8'h00, r);
    check("R7 disable cmd", r, 8'h00);

    // R7 disable-pattern byte without configure has no effect
    send_cmd(8'h05);
    send_cmd(8'h6B);
    send_cmd(8'h75);
    poll_at(8'h40, r);
    check("R7 unarmed disable ignored", r, 8'h08);

    // R9 reset clears mask and config
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 mask after reset", reg_rdata, 8'h00);
    poll_at(8'hFF, r);
    check("R9 config after reset", r, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule